// File: doc/BRIEF.md
# Host Interrupt Status and Mask Unit

This block collects event pulses from the rest of a storage controller and holds each of them in a sticky interrupt status register. The host reads that register through a small word-addressed register port and acknowledges events by writing ones to the bits it has serviced. A mask register with the same bit layout selects which latched events may raise the single level interrupt line. A global enable bit in a control register gates that line as a whole.

Alongside the level line, the block turns each newly latched event into a 4-bit message-signalled interrupt code. A downstream transport can use that code to build its message write. Codes are issued one per cycle from a small pending set. Two reset commands in the control register give the host a full restart and a status-only restart.

Top module: `hostirq_ctrl`

## Requirements
- R1: After `rst_n` is released, status reads 0x000, mask reads 0x7E7, control reads 0x00, `irq_o` is 0 and `msi_valid_o` is 0.
- R2: An `evt_i` pulse on bit 0, 1, 2, 5, 6, 7, 8, 9 or 10 sets the same status bit (word offset 0) at the next clock edge. Status bits 3 and 4, and every bit above 10, never set and always read 0.
- R3: A write to status sets to 0 each bit whose write data bit is 1 and leaves each bit whose write data bit is 0 unchanged.
- R4: An event pulse on a bit in the same cycle as a write of 1 to that bit leaves the bit set.
- R5: The mask register (word offset 1) stores write data bits 0–2 and 5–10. The other bits read 0.
- R6: `irq_o` is 1 exactly when control bit 7 (interrupt enable) is 1 and at least one bit is set in both status and mask.
- R7: When a status bit goes from 0 to 1, `msi_valid_o` pulses for one cycle after that edge with a code: bit0→4, bit1→5, bit2→6, bit5→9, bit6→10, bit7→11, bit8→12. A repeated event on a bit that is already set emits no code.
- R8: When several coded bits rise at one edge, their codes appear on consecutive cycles in ascending bit order.
- R9: Events on bit 9 (command FIFO overrun) and bit 10 (bad expansion-ROM read) latch in status but emit no code.
- R10: Writing control (word offset 2) with bit 1 set clears status and any pending codes. The mask stays unchanged, and control bit 7 and bit 6 take the write data.
- R11: Writing control with bit 0 set clears status, pending codes, mask and control.
- R12: Control bit 6 (timestamp disable) and bit 7 read back as written. Control bits 0 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 11 | Event pulses, one per status bit position |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word offset: 0 status, 1 mask, 2 control |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt |
| msi_valid_o | output | 1 | Message code valid, one cycle per code |
| msi_code_o | output | 4 | Message-signalled interrupt code |

## Verification
The hardest situation to reach is an event pulse and a host clear of the same bit landing in the same clock cycle. The bench drives `evt_i` and the status write at the same falling edge, so both arrive at one rising edge. It does this once for a bit that is already set, to check that the bit stays set and no code is issued, and once for a bit that is clear, to check that a code is issued. Draining the pending codes is also hard to observe. The bench raises seven coded bits at once and follows the code on every cycle, and separately interrupts a drain with a status-only reset.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;
    localparam int REG_W  = 32;
    localparam int EVT_W  = 11;
    localparam int CODE_W = 4;
    localparam int ADDR_W = 2;

    localparam logic [EVT_W-1:0] DEF_EVT   = 11'h7E7;
    localparam logic [EVT_W-1:0] CODED_EVT = 11'h1E7;

    localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK   = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

    localparam int C_HARD  = 0;
    localparam int C_SOFT  = 1;
    localparam int C_TSDIS = 6;
    localparam int C_IEN   = 7;

    function automatic logic [CODE_W-1:0] evt_code(input int idx);
        case (idx)
            0:       return 4'd4;
            1:       return 4'd5;
            2:       return 4'd6;
            5:       return 4'd9;
            6:       return 4'd10;
            7:       return 4'd11;
            8:       return 4'd12;
            default: return 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/hostirq_status.sv
module hostirq_status
    import hostirq_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    input  logic         flush_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.bits = '0;
        end else begin
            // an event in the same cycle as a clear wins
            st_d.bits = ((st_q.bits & ~clr_i) | evt_i) & DEF_EVT[W-1:0];
        end
        rise_o = st_d.bits & ~st_q.bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.bits;
endmodule

// File: rtl/hostirq_msi.sv
module hostirq_msi
    import hostirq_pkg::*;
#(
    parameter int W  = EVT_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  rise_i,
    input  logic          flush_i,
    output logic          valid_o,
    output logic [CW-1:0] code_o
);
    typedef struct packed {
        logic [W-1:0] pend;
    } ms_t;

    ms_t ms_d, ms_q;
    logic [W-1:0] grant;
    int           sel;

    // lowest pending bit is served first
    always_comb begin
        grant = '0;
        sel   = 0;
        for (int i = W - 1; i >= 0; i--) begin
            if (ms_q.pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                sel      = i;
            end
        end
    end

    always_comb begin
        ms_d = ms_q;
        if (flush_i) ms_d.pend = '0;
        else         ms_d.pend = (ms_q.pend & ~grant) | (rise_i & CODED_EVT[W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ms_q <= '0;
        else        ms_q <= ms_d;
    end

    assign valid_o = |ms_q.pend;
    assign code_o  = valid_o ? CW'(evt_code(sel)) : '0;
endmodule

// File: rtl/hostirq_ctrl.sv
module hostirq_ctrl
    import hostirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o,
    output logic              msi_valid_o,
    output logic [CODE_W-1:0] msi_code_o
);
    typedef struct packed {
        logic [EVT_W-1:0] mask;
        logic             ien;
        logic             tsdis;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic             wr_status, wr_mask, wr_ctrl;
    logic             hard_rst, soft_rst, flush;
    logic [EVT_W-1:0] clr_vec, status_w, rise_w, mask_w;
    logic             ien_w;
    logic             unused_wbits;

    assign wr_status = wr_en_i && (addr_i == A_STATUS);
    assign wr_mask   = wr_en_i && (addr_i == A_MASK);
    assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
    assign hard_rst  = wr_ctrl && wdata_i[C_HARD];
    assign soft_rst  = wr_ctrl && wdata_i[C_SOFT];
    assign flush     = hard_rst || soft_rst;
    assign clr_vec   = wr_status ? wdata_i[EVT_W-1:0] : '0;
    assign unused_wbits = ^{wdata_i[REG_W-1:EVT_W]};

    always_comb begin
        cfg_d = cfg_q;
        if (hard_rst) begin
            cfg_d = '0;
        end else begin
            if (wr_ctrl) begin
                cfg_d.ien   = wdata_i[C_IEN];
                cfg_d.tsdis = wdata_i[C_TSDIS];
            end
            if (wr_mask) cfg_d.mask = wdata_i[EVT_W-1:0] & DEF_EVT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask  <= DEF_EVT;
            cfg_q.ien   <= 1'b0;
            cfg_q.tsdis <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_w = cfg_q.mask;
    assign ien_w  = cfg_q.ien;

    hostirq_status #(.W(EVT_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (clr_vec),
        .flush_i  (flush),
        .status_o (status_w),
        .rise_o   (rise_w)
    );

    hostirq_msi #(.W(EVT_W), .CW(CODE_W)) u_msi (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_w),
        .flush_i (flush),
        .valid_o (msi_valid_o),
        .code_o  (msi_code_o)
    );

    assign irq_o = ien_w && |(status_w & mask_w);

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_STATUS: rdata_o = REG_W'(status_w);
            A_MASK:   rdata_o = REG_W'(mask_w);
            A_CTRL: begin
                rdata_o[C_IEN]   = cfg_q.ien;
                rdata_o[C_TSDIS] = cfg_q.tsdis;
            end
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/hostirq_ctrl_chk.sv
module hostirq_ctrl_chk
    import hostirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [EVT_W-1:0]  evt_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [REG_W-1:0]  wdata_i,
    input logic [EVT_W-1:0]  status,
    input logic [EVT_W-1:0]  mask,
    input logic              ien,
    input logic              irq_o,
    input logic              msi_valid_o,
    input logic [CODE_W-1:0] msi_code_o
);
    logic rst_cmd;
    assign rst_cmd = wr_en_i && (addr_i == A_CTRL) && (wdata_i[C_HARD] || wdata_i[C_SOFT]);

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~DEF_EVT) == '0) && ((mask & ~DEF_EVT) == '0)); // R2

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & DEF_EVT) && !rst_cmd) |=>
        ((status & $past(evt_i & DEF_EVT)) == $past(evt_i & DEF_EVT))); // R4

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_STATUS) |=>
        ((status & $past(wdata_i[EVT_W-1:0] & ~evt_i)) == '0)); // R3

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq_o); // R6

    AST_MSI_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid_o |-> ((msi_code_o >= 4'd4 && msi_code_o <= 4'd6) ||
                         (msi_code_o >= 4'd9 && msi_code_o <= 4'd12))); // R7

    AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_CTRL && wdata_i[C_SOFT] && !wdata_i[C_HARD]) |=>
        (status == '0 && $stable(mask) && !msi_valid_o)); // R10

    AST_HARD_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_CTRL && wdata_i[C_HARD]) |=>
        (status == '0 && mask == '0 && !ien && !irq_o)); // R11
endmodule

bind hostirq_ctrl hostirq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .status      (status_w),
    .mask        (mask_w),
    .ien         (ien_w),
    .irq_o       (irq_o),
    .msi_valid_o (msi_valid_o),
    .msi_code_o  (msi_code_o)
);

// File: tb/test_hostirq_ctrl.sv
module test_hostirq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] evt_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o, msi_valid_o;
    logic [3:0]  msi_code_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    hostirq_ctrl i_hostirq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .irq_o(irq_o), .msi_valid_o(msi_valid_o), .msi_code_o(msi_code_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
        addr_i = a;
        #1;
        chk(req, rdata_o, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic pulse(input logic [10:0] e);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic msi(input string req, input logic v, input logic [3:0] c);
        chk(req, {31'd0, msi_valid_o}, {31'd0, v});
        if (v) chk(req, {28'd0, msi_code_o}, {28'd0, c});
    endtask

    task automatic t_reset();
        rd("R1 status", 2'd0, 32'h0);
        rd("R1 mask", 2'd1, 32'h7E7);
        rd("R1 ctrl", 2'd2, 32'h0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        msi("R1 msi", 1'b0, 4'd0);
    endtask

    task automatic t_all_codes();
        pulse(11'h7FF);
        msi("R8 first", 1'b1, 4'd4);
        @(negedge clk); msi("R8 seq", 1'b1, 4'd5);
        @(negedge clk); msi("R8 seq", 1'b1, 4'd6);
        @(negedge clk); msi("R8 seq", 1'b1, 4'd9);
        @(negedge clk); msi("R8 seq", 1'b1, 4'd10);
        @(negedge clk); msi("R8 seq", 1'b1, 4'd11);
        @(negedge clk); msi("R8 seq", 1'b1, 4'd12);
        @(negedge clk); msi("R7 drained", 1'b0, 4'd0);
        rd("R2 reserved bits", 2'd0, 32'h7E7);
    endtask

    task automatic t_w1c();
        wr(2'd0, 32'h0);
        rd("R3 zero write", 2'd0, 32'h7E7);
        wr(2'd0, 32'h005);
        rd("R3 clear", 2'd0, 32'h7E2);
        wr(2'd0, 32'hFFFF_F7E0);
        rd("R3 clear", 2'd0, 32'h002);
    endtask

    task automatic t_race();
        evt_i = 11'h002;
        wr(2'd0, 32'h7FF);
        evt_i = '0;
        rd("R4 held bit", 2'd0, 32'h002);
        msi("R4 no re-emit", 1'b0, 4'd0);
        evt_i = 11'h001;
        wr(2'd0, 32'h001);
        evt_i = '0;
        rd("R4 new bit", 2'd0, 32'h003);
        msi("R4 code", 1'b1, 4'd4);
        wr(2'd0, 32'h001);
        rd("R4 cleanup", 2'd0, 32'h002);
    endtask

    task automatic t_irq();
        chk("R6 disabled", {31'd0, irq_o}, 32'd0);
        wr(2'd2, 32'h80);
        chk("R6 enabled", {31'd0, irq_o}, 32'd1);
        wr(2'd1, 32'hFFFF_FFFF);
        rd("R5 mask bits", 2'd1, 32'h7E7);
        wr(2'd1, 32'h7E5);
        chk("R6 masked", {31'd0, irq_o}, 32'd0);
        wr(2'd1, 32'h002);
        chk("R6 unmasked", {31'd0, irq_o}, 32'd1);
        wr(2'd2, 32'h00);
        chk("R6 global off", {31'd0, irq_o}, 32'd0);
        wr(2'd2, 32'h80);
    endtask

    task automatic t_nocode();
        pulse(11'h600);
        msi("R9 no code", 1'b0, 4'd0);
        @(negedge clk);
        msi("R9 still none", 1'b0, 4'd0);
        rd("R9 latched", 2'd0, 32'h602);
    endtask

    task automatic t_held();
        pulse(11'h002);
        msi("R7 held", 1'b0, 4'd0);
        wr(2'd0, 32'h002);
        pulse(11'h002);
        msi("R7 rise", 1'b1, 4'd5);
        @(negedge clk);
        msi("R7 one cycle", 1'b0, 4'd0);
    endtask

    task automatic t_soft();
        pulse(11'h1E5);
        msi("R10 pre", 1'b1, 4'd4);
        wr(2'd2, 32'hC2);
        msi("R10 flushed", 1'b0, 4'd0);
        rd("R10 status", 2'd0, 32'h0);
        rd("R10 mask kept", 2'd1, 32'h002);
        rd("R12 ctrl", 2'd2, 32'hC0);
    endtask

    task automatic t_hard();
        pulse(11'h001);
        wr(2'd2, 32'h81);
        rd("R11 status", 2'd0, 32'h0);
        rd("R11 mask", 2'd1, 32'h0);
        rd("R11 ctrl", 2'd2, 32'h0);
        chk("R11 irq", {31'd0, irq_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_codes();
        t_w1c();
        t_race();
        t_irq();
        t_nocode();
        t_held();
        t_soft();
        t_hard();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule